// File: doc/BRIEF.md
# Dual-Port I2C Register Slave

This block is a slave on a two-wire serial bus. It reaches a register bank through a small, synchronous strobe interface. The system clock oversamples SCL and SDA. Each line passes through a synchroniser and a glitch filter. Edge logic then turns the two filtered lines into bit events and into START and STOP events. The slave answers to two 7-bit addresses on the same bus: a control port and a readback port. A strap pin sets the low address bit of both ports, so two copies of the block can share one bus. SDA is open-drain. The block only asserts `sda_oe` to pull the line low.

A write transfer carries three parts in order: the address byte, a starting subaddress, and then any number of data bytes. The data bytes go to consecutive registers. A read first sets the subaddress with a write. A repeated START and the read address follow. The slave then returns bytes from the pointer until the master answers with a NACK. The register map runs from 0 to `REG_TOP`. A write past the top is refused. A read past the top returns the top register again.

The controller has nine states. `ST_IDLE` waits for a START. `ST_ADDR`, `ST_SUB` and `ST_WDATA` shift in a byte, and `ST_ADDR_ACK`, `ST_SUB_ACK` and `ST_WDATA_ACK` drive the ACK slot. `ST_RDATA` shifts out a byte, and `ST_RDATA_ACK` samples the master's answer. The transitions are as follows:
- Any START leads to `ST_ADDR`, and any STOP leads to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ADDR_ACK` on an address match, and otherwise to `ST_IDLE`.
- `ST_ADDR_ACK` moves to `ST_SUB` for a write, or to `ST_RDATA` for a read.
- `ST_SUB` moves to `ST_SUB_ACK` when the subaddress is in the map, and otherwise to `ST_IDLE`.
- `ST_SUB_ACK` moves to `ST_WDATA`.
- `ST_WDATA` moves to `ST_WDATA_ACK` while the pointer is in the map, and otherwise to `ST_IDLE`.
- `ST_WDATA_ACK` moves back to `ST_WDATA`.
- `ST_RDATA` moves to `ST_RDATA_ACK` after eight bits.
- `ST_RDATA_ACK` moves to `ST_RDATA` on a master ACK, or to `ST_IDLE` on a NACK.

Top module: `i2c_regport_slave`

## Requirements
- R1: With `addr_sel` low, the control port acknowledges the address bytes 0x40 (write) and 0x41 (read). With `addr_sel` high, it acknowledges 0x42 and 0x43 instead. The strap drives bit 1 of the address byte, and bit 0 of the byte selects the direction (0 = master writes, 1 = master reads).
- R2: The readback port acknowledges 0x20 and 0x21 with `addr_sel` low, and 0x22 and 0x23 with it high. After an acknowledged address, `port_rdbk` reads 1 for the readback port and 0 for the control port.
- R3: Any other address byte gets no ACK. The slave then ignores the bus until the next START.
- R4: A START (SDA falls while SCL is high) restarts the address phase from any state. A STOP (SDA rises while SCL is high) returns the slave to idle from any state. A STOP followed by a START within one SCL high period opens a new transfer.
- R5: In a write, the byte after the address loads the pointer. Each later byte that is acknowledged gives one `reg_wr_en` pulse, with `reg_addr` set to the pointer and `reg_wdata` set to the byte. The pointer then steps by one.
- R6: A subaddress byte above `REG_TOP` (0xC3 by default) gets no ACK, and the slave returns to idle.
- R7: A write byte that arrives after the pointer has passed `REG_TOP` is not stored and gets no ACK, and the slave returns to idle.
- R8: After a read address, the slave shifts out the register at the pointer, MSB first. Each bit is placed after an SCL falling edge. Each byte the master acknowledges is followed by the next register.
- R9: A read that steps past `REG_TOP` sends the top register again for every further byte.
- R10: A master NACK in the ninth slot of a read ends the transfer. The slave releases SDA and idles.
- R11: An SCL pulse of one system-clock sample is ignored. While filtered SCL stays high, `sda_oe` changes only in response to a START or a STOP.
- R12: After reset, `sda_oe`, `reg_wr_en`, `reg_rd_req` and `port_rdbk` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen at the pin |
| sda_in | input | 1 | Serial data line as seen at the pin |
| addr_sel | input | 1 | Strap that sets the low bit of both 7-bit addresses |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| port_rdbk | output | 1 | The last acknowledged address belongs to the readback port |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_req | output | 1 | One-cycle register read request; `reg_rdata` is captured in the same cycle |
| reg_addr | output | 8 | Current subaddress pointer |
| reg_wdata | output | 8 | Byte to write |
| reg_rdata | input | 8 | Register contents at `reg_addr` |

## Verification
A wrong internal state shows up at the ports within one byte time. It appears as a missing or extra ACK in the ninth slot, as a write strobe at the wrong subaddress, or as a wrong bit shifted out on the next SCL low phase. The bench sweeps every 7-bit address under both strap levels and compares the ACK with the two expected ports. It then runs writes and reads across the top of the map, and it breaks transfers with early STOPs, early STARTs and SCL glitches. After each of these, it checks the register model and the next ACK slot, so that a pointer or a state left over from a broken transfer shows up in the following byte.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_t;

endpackage

// File: rtl/regslv_line_filter.sv
module regslv_line_filter #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              hold_q;

    // Synchroniser chain, then the output follows only two agreeing samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q   <= '1;
            hold_q   <= 1'b1;
            line_out <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_in};
            hold_q <= sync_q[LAST];
            if (sync_q[LAST] == hold_q && hold_q != line_out) begin
                line_out <= hold_q;
            end
        end
    end

endmodule

// File: rtl/regslv_bus_events.sv
module regslv_bus_events #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] filt;
    logic [LINES-1:0] filt_d;

    assign raw = {sda_in, scl_in};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            regslv_line_filter #(.STAGES(STAGES)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .line_in  (raw[g]),
                .line_out (filt[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_d <= '1;
        else        filt_d <= filt;
    end

    assign scl_lvl  = filt[0];
    assign sda_lvl  = filt[1];
    assign scl_rise = filt[0] & ~filt_d[0];
    assign scl_fall = ~filt[0] & filt_d[0];
    assign start_ev = filt[0] & filt_d[0] & filt_d[1] & ~filt[1];
    assign stop_ev  = filt[0] & filt_d[0] & ~filt_d[1] & filt[1];

endmodule

// File: rtl/regslv_subaddr_ptr.sv
module regslv_subaddr_ptr #(
    parameter int REG_TOP = 195
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       step,
    input  logic       sat_read,
    output logic [7:0] ptr,
    output logic       ptr_ok
);

    localparam logic [7:0] TOP    = REG_TOP[7:0];
    localparam logic [8:0] TOP_P1 = {1'b0, TOP} + 9'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            if (sat_read) ptr <= (ptr >= TOP) ? TOP : ptr + 8'd1;
            else          ptr <= (ptr > TOP) ? ptr : ptr + 8'd1;
        end
    end

    assign ptr_ok = (ptr <= TOP);

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, ptr} <= TOP_P1) else $error("pointer beyond top+1"); // R7

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
    import regslv_pkg::*;
#(
    parameter int         REG_TOP     = 195,
    parameter logic [6:0] CTRL_ADDR7  = 7'h20,
    parameter logic [6:0] RDBK_ADDR7  = 7'h10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       addr_sel,
    output logic       sda_oe,
    output logic       port_rdbk,
    output logic       reg_wr_en,
    output logic       reg_rd_req,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata
);

    localparam logic [7:0] TOP      = REG_TOP[7:0];
    localparam logic [3:0] FULL_CNT = 4'(BYTE_BITS);
    localparam logic [3:0] LAST_TX  = 4'(BYTE_BITS - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

    regslv_bus_events #(.STAGES(SYNC_STAGES)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    slv_state_t state_q, state_d;
    logic [3:0] bit_q;
    logic [7:0] rx_q, tx_q;
    logic       rw_q, port_q, mack_q;

    logic       ptr_load, ptr_step, ptr_ok;
    logic [7:0] ptr;

    regslv_subaddr_ptr #(.REG_TOP(REG_TOP)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (rx_q),
        .step     (ptr_step),
        .sat_read (reg_rd_req),
        .ptr      (ptr),
        .ptr_ok   (ptr_ok)
    );

    logic byte_done, hit_ctrl, hit_rdbk, sub_ok, rx_state;

    assign byte_done = scl_fall && (bit_q == FULL_CNT);
    assign hit_ctrl  = (rx_q[7:1] == (CTRL_ADDR7 | {6'd0, addr_sel}));
    assign hit_rdbk  = (rx_q[7:1] == (RDBK_ADDR7 | {6'd0, addr_sel}));
    assign sub_ok    = (rx_q <= TOP);
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_WDATA);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_done) state_d = (hit_ctrl || hit_rdbk) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall)  state_d = rw_q ? ST_RDATA : ST_SUB;
                ST_SUB:       if (byte_done) state_d = sub_ok ? ST_SUB_ACK : ST_IDLE;
                ST_SUB_ACK:   if (scl_fall)  state_d = ST_WDATA;
                ST_WDATA:     if (byte_done) state_d = ptr_ok ? ST_WDATA_ACK : ST_IDLE;
                ST_WDATA_ACK: if (scl_fall)  state_d = ST_WDATA;
                ST_RDATA:     if (scl_fall && bit_q == LAST_TX) state_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)  state_d = mack_q ? ST_RDATA : ST_IDLE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Shift, count and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '1;
            rw_q   <= 1'b0;
            port_q <= 1'b0;
            mack_q <= 1'b0;
        end else if (start_ev) begin
            bit_q <= '0;
        end else begin
            if (rx_state && scl_rise) begin
                rx_q  <= {rx_q[6:0], sda_lvl};
                bit_q <= bit_q + 4'd1;
            end
            if (state_q == ST_ADDR && byte_done && (hit_ctrl || hit_rdbk)) begin
                rw_q   <= rx_q[0];
                port_q <= hit_rdbk;
            end
            if (scl_fall && (state_q == ST_ADDR_ACK || state_q == ST_SUB_ACK ||
                             state_q == ST_WDATA_ACK || state_q == ST_RDATA_ACK)) begin
                bit_q <= '0;
            end
            if (state_q == ST_RDATA && scl_fall && bit_q != LAST_TX) begin
                tx_q  <= {tx_q[6:0], 1'b1};
                bit_q <= bit_q + 4'd1;
            end
            if (state_q == ST_RDATA_ACK && scl_rise) begin
                mack_q <= ~sda_lvl;
            end
            if (reg_rd_req) begin
                tx_q <= reg_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe     = 1'b0;
        reg_wr_en  = 1'b0;
        reg_rd_req = 1'b0;
        ptr_load   = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK: begin
                sda_oe     = 1'b1;
                reg_rd_req = scl_fall && rw_q && !start_ev && !stop_ev;
            end
            ST_SUB_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_SUB:   ptr_load  = byte_done && sub_ok && !start_ev && !stop_ev;
            ST_WDATA: reg_wr_en = byte_done && ptr_ok && !start_ev && !stop_ev;
            ST_RDATA: sda_oe    = ~tx_q[7];
            ST_RDATA_ACK: reg_rd_req = scl_fall && mack_q && !start_ev && !stop_ev;
            default: ;
        endcase
    end

    assign ptr_step  = reg_wr_en | reg_rd_req;
    assign reg_addr  = ptr;
    assign reg_wdata = rx_q;
    assign port_rdbk = port_q;

    AST_WR_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (reg_addr <= TOP)) else $error("write outside map"); // R7

    AST_RD_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_req |-> (reg_addr <= TOP)) else $error("read outside map"); // R9

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state_q == ST_IDLE)) else $error("stop did not idle"); // R4

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en) else $error("write strobe too long"); // R5

    AST_OE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe))
        else $error("sda drive moved during scl high"); // R11

endmodule

// File: tb/tb_i2c_regport_slave.sv
`timescale 1ns/1ps
module tb_i2c_regport_slave;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n, scl_m, m_low, addr_sel;
    logic       sda_line, sda_oe, port_rdbk, reg_wr_en, reg_rd_req;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic [7:0] mem [0:255];
    logic [7:0] exp_mem [0:255];
    int         wr_cnt, n_chk, n_fail;
    bit         done;

    always #2.5 clk = ~clk;

    assign sda_line  = ~(m_low | sda_oe);
    assign reg_rdata = mem[reg_addr];

    i2c_regport_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .addr_sel(addr_sel),
        .sda_oe(sda_oe), .port_rdbk(port_rdbk), .reg_wr_en(reg_wr_en), .reg_rd_req(reg_rd_req),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] seed(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= seed(i);
            wr_cnt <= 0;
        end else if (reg_wr_en) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
    endtask

    task automatic rep_start();
        tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); m_low = 1'b0; tick(Q);
    endtask

    task automatic put_bit(input bit b, input bit glitch);
        tick(Q); m_low = ~b;
        if (glitch) begin scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(Q - 1); end
        else tick(Q);
        scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input int glitch_at, output bit ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i], i == glitch_at);
        tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q); scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_low = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q); scl_m = 1'b0;
        end
        tick(Q); m_low = mack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0;
    endtask

    initial begin
        bit         ack;
        logic [7:0] rd;
        int         w0;
        n_chk = 0; n_fail = 0; done = 1'b0;
        rst_n = 1'b0; scl_m = 1'b1; m_low = 1'b0; addr_sel = 1'b0;
        tick(10);
        for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);
        rst_n = 1'b1;
        tick(4);
        // R12 reset state
        check("R12 sda_oe", sda_oe, 0);
        check("R12 wr_en", reg_wr_en, 0);
        check("R12 rd_req", reg_rd_req, 0);
        check("R12 port_rdbk", port_rdbk, 0);

        // R1 R2 R3 address sweep, write direction, both strap levels
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            for (int a = 0; a < 128; a++) begin
                bit is_ctrl, is_rdbk;
                is_ctrl = (a == (32 | s));
                is_rdbk = (a == (16 | s));
                bus_start();
                send_byte({a[6:0], 1'b0}, -1, ack);
                check(is_ctrl ? "R1 ctrl ack" : (is_rdbk ? "R2 rdbk ack" : "R3 no ack"),
                      ack, int'(is_ctrl || is_rdbk));
                if (is_ctrl || is_rdbk) check("R2 port flag", port_rdbk, int'(is_rdbk));
                bus_stop();
            end
        end
        addr_sel = 1'b0;

        // R5 burst write with an SCL glitch inside the second data byte (R11)
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h40, -1, ack); check("R1 addr 0x40", ack, 1);
        send_byte(8'h10, -1, ack); check("R5 sub ack", ack, 1);
        send_byte(8'hA5, -1, ack); check("R5 data0 ack", ack, 1);
        send_byte(8'h3C,  4, ack); check("R11 glitch byte ack", ack, 1);
        send_byte(8'h7E, -1, ack); check("R5 data2 ack", ack, 1);
        bus_stop();
        exp_mem[8'h10] = 8'hA5; exp_mem[8'h11] = 8'h3C; exp_mem[8'h12] = 8'h7E;
        check("R5 mem10", mem[8'h10], exp_mem[8'h10]);
        check("R11 mem11", mem[8'h11], exp_mem[8'h11]);
        check("R5 mem12", mem[8'h12], exp_mem[8'h12]);
        check("R5 write count", wr_cnt - w0, 3);

        // R2 write through the readback port with the strap high
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h22, -1, ack); check("R2 addr 0x22", ack, 1);
        check("R2 port flag high", port_rdbk, 1);
        send_byte(8'h50, -1, ack);
        send_byte(8'h99, -1, ack); check("R2 data ack", ack, 1);
        bus_stop();
        exp_mem[8'h50] = 8'h99;
        check("R2 mem50", mem[8'h50], 8'h99);
        addr_sel = 1'b0;

        // R6 invalid subaddresses
        for (int k = 0; k < 2; k++) begin
            w0 = wr_cnt;
            bus_start();
            send_byte(8'h40, -1, ack);
            send_byte(k == 0 ? 8'hC4 : 8'hFF, -1, ack); check("R6 bad sub nack", ack, 0);
            send_byte(8'h55, -1, ack); check("R6 idle after bad sub", ack, 0);
            bus_stop();
            check("R6 no write", wr_cnt - w0, 0);
        end

        // R7 write past the top
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h40, -1, ack);
        send_byte(8'hC2, -1, ack); check("R7 sub C2 ack", ack, 1);
        send_byte(8'h11, -1, ack); check("R7 C2 ack", ack, 1);
        send_byte(8'h22, -1, ack); check("R7 C3 ack", ack, 1);
        send_byte(8'h33, -1, ack); check("R7 past top nack", ack, 0);
        send_byte(8'h44, -1, ack); check("R7 idle after top", ack, 0);
        bus_stop();
        exp_mem[8'hC2] = 8'h11; exp_mem[8'hC3] = 8'h22;
        check("R7 write count", wr_cnt - w0, 2);
        check("R7 memC3", mem[8'hC3], 8'h22);

        // R8 R10 normal read
        bus_start();
        send_byte(8'h40, -1, ack);
        send_byte(8'h05, -1, ack);
        rep_start();
        send_byte(8'h41, -1, ack); check("R8 read addr ack", ack, 1);
        for (int j = 0; j < 3; j++) begin
            recv_byte(j != 2, rd);
            check("R8 read data", rd, exp_mem[5 + j]);
        end
        tick(Q);
        check("R10 released after nack", sda_oe, 0);
        bus_stop();

        // R9 read across the top
        bus_start();
        send_byte(8'h40, -1, ack);
        send_byte(8'hC1, -1, ack);
        rep_start();
        send_byte(8'h41, -1, ack);
        for (int j = 0; j < 4; j++) begin
            recv_byte(j != 3, rd);
            check("R9 read top", rd, exp_mem[(j < 2) ? 8'hC1 + j : 8'hC3]);
        end
        bus_stop();

        // R4 STOP inside a data byte, then clocking without START is ignored
        w0 = wr_cnt;
        bus_start();
        send_byte(8'h40, -1, ack);
        send_byte(8'h30, -1, ack);
        put_bit(1'b0, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0);
        bus_stop();
        tick(Q); scl_m = 1'b0;
        send_byte(8'hAA, -1, ack); check("R4 idle after stop", ack, 0);
        bus_stop();
        check("R4 no write after stop", wr_cnt - w0, 0);
        check("R4 mem30", mem[8'h30], exp_mem[8'h30]);

        // R4 START inside a data byte, pointer kept, read from the readback port
        bus_start();
        send_byte(8'h40, -1, ack);
        send_byte(8'h20, -1, ack);
        put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0); put_bit(1'b1, 1'b0); put_bit(1'b1, 1'b0);
        rep_start();
        send_byte(8'h21, -1, ack); check("R4 restart ack", ack, 1);
        check("R2 read port flag", port_rdbk, 1);
        recv_byte(1'b0, rd); check("R8 read after restart", rd, exp_mem[8'h20]);
        bus_stop();
        check("R4 no write after restart", wr_cnt - w0, 0);

        // R4 STOP then START within one SCL high period
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h42, -1, ack);
        tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q); m_low = 1'b1; tick(Q); scl_m = 1'b0;
        send_byte(8'h42, -1, ack); check("R4 stop+start ack", ack, 1);
        check("R1 strap high ctrl", port_rdbk, 0);
        bus_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule